// File: doc/BRIEF.md
# Line-Locked Raster Timing Follower

This block recovers raster timing for a video encoder that runs as a timing slave. It takes an external line sync and a field input. The field input is either a level flag that changes between odd and even fields, or a vertical sync pulse. Both inputs pass through a shared programmable delay of zero to three clocks, and each has its own active-edge polarity. The block keeps a sample counter, a line counter and a field counter. It reports the luma/chroma component phase of the current sample and the parity of the current field.

Each line is started by the external line sync, never by an internal period. An early line sync cuts the line short and restarts all timing at once. If the line sync is late, the sample counter stops at the nominal last sample and waits for it. The nominal line length is a runtime input, so one instance serves both 525-line and 625-line rasters. Encoding starts at the first line sync that arrives at or after the first active field edge. In pulse mode, each active vertical sync edge toggles an internal odd/even flag. From there the block behaves exactly as in flag mode.

Top module: `raster_sync_follower`

## Requirements
- R1: Reset sets sample_cnt, line_cnt and field_cnt to zero, comp_phase to Cb (code 0) and encoding to 0. With the field input idle at its inactive level, field_odd is also 0.
- R2: cfg_h_rise=1 makes a low-to-high change of hsync_in the active line edge, and 0 selects high-to-low. cfg_f_rise selects the active edge of field_in in the same way.
- R3: cfg_sync_dly (0..3) delays both sync inputs equally by that many clocks. With value d, an active line edge driven before clock edge 1 gives sample_cnt = k-1-d after clock edge k (k > d), until the count holds.
- R4: encoding stays 0 until the first active line edge that is detected in the same cycle as, or after, the first active field edge. It then stays 1 until reset. Line edges seen before that leave every counter at zero.
- R5: Once encoding, every active line edge sets sample_cnt to 0 and comp_phase to Cb on the next clock. This also holds when the edge comes before the nominal line end.
- R6: Between line edges, sample_cnt rises by one per clock up to cfg_line_len-1. It holds that value until the next active line edge.
- R7: comp_phase cycles Cb(0), Y(1), Cr(2), Y(3) in step with sample_cnt. It equals sample_cnt mod 4 and holds while the count holds.
- R8: Each active line edge while encoding raises line_cnt by one. The first active line edge at or after each active field edge clears line_cnt to 0 instead.
- R9: Flag mode (cfg_field_pulse=0): field_cnt advances on every change of the delayed field input, both rising and falling. field_odd is 1 while that input is at its active level. Only the active edge arms the line clear of R8.
- R10: Pulse mode (cfg_field_pulse=1): each active edge of field_in toggles field_odd, advances field_cnt and arms the line clear. The inactive edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; sync inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_field_pulse | input | 1 | 0: field input is an odd/even flag, 1: vertical sync pulse |
| cfg_h_rise | input | 1 | Line sync active edge: 1 rising, 0 falling |
| cfg_f_rise | input | 1 | Field input active edge: 1 rising, 0 falling |
| cfg_sync_dly | input | DLY_W | Delay of both sync inputs in clocks |
| cfg_line_len | input | SAMPLE_W | Nominal samples per line (at least 2) |
| hsync_in | input | 1 | External line sync |
| field_in | input | 1 | External field flag or vertical sync |
| sample_cnt | output | SAMPLE_W | Sample index within the line |
| line_cnt | output | LINE_W | Line index since the last field-aligned clear |
| field_cnt | output | FIELD_W | Field count, wraps |
| comp_phase | output | 2 | 0 Cb, 1 Y, 2 Cr, 3 Y |
| encoding | output | 1 | High once the raster has locked |
| field_odd | output | 1 | Current field parity |

## Verification
The hardest case to reach is an active field edge and an active line edge detected in the same cycle, behind a non-zero delay. That cycle must both start encoding and clear the line counter. The bench drives both inputs at the same falling clock edge, for every combination of mode, both polarities and all four delays. It then checks sample counts computed from the delay. Long-line holding, early restarts and the inactive field edge are exercised in each of these configurations.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_Y0 = 2'd1,
      PH_CR = 2'd2,
      PH_Y1 = 2'd3
   } comp_phase_e;

   function automatic comp_phase_e phase_step(comp_phase_e p);
      return comp_phase_e'(p + 2'd1);
   endfunction

endpackage

// File: rtl/rsf_sync_tap.sv
module rsf_sync_tap #(
   parameter int MAX_DLY = 3,
   parameter int DLY_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             rise_active,
   input  logic [DLY_W-1:0] dly,
   output logic             level,
   output logic             act_edge,
   output logic             any_edge,
   output logic             primed
);
   localparam int PRIME_N = MAX_DLY + 1;
   localparam int PRIME_W = $clog2(PRIME_N + 1);

   generate
      if (MAX_DLY < 1) begin : g_bad_dly
         $error("rsf_sync_tap: MAX_DLY must be at least 1");
      end
      if (MAX_DLY >= (1 << DLY_W)) begin : g_bad_w
         $error("rsf_sync_tap: DLY_W too narrow for MAX_DLY");
      end
   endgenerate

   logic [MAX_DLY-1:0] dline;
   logic               tapped;
   logic               prev;
   logic [PRIME_W-1:0] pcnt;

   generate
      if (MAX_DLY == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dline <= '0;
            else        dline <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dline <= '0;
            else        dline <= {dline[MAX_DLY-2:0], din};
         end
      end
   endgenerate

   always_comb begin
      tapped = din;
      for (int i = 0; i < MAX_DLY; i++) begin
         if (int'(dly) == i + 1) tapped = dline[i];
      end
   end

   assign primed = (pcnt == PRIME_W'(PRIME_N));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         prev <= 1'b0;
      end else begin
         prev <= tapped;
         if (!primed) pcnt <= pcnt + 1'b1;
      end
   end

   assign level    = tapped;
   assign any_edge = primed & (tapped ^ prev);
   assign act_edge = any_edge & (tapped == rise_active);

   // R3: a one-clock setting presents the input seen one clock earlier
   a_r3_one_clock_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && int'(dly) == 1) |-> level == $past(din));

   // R2: an active edge lands on the level chosen by the polarity bit
   a_r2_active_level: assert property (@(posedge clk) disable iff (!rst_n)
      act_edge |-> (level == rise_active && $past(level) != rise_active));

endmodule

// File: rtl/rsf_field_track.sv
module rsf_field_track #(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pulse_mode,
   input  logic               rise_active,
   input  logic               level,
   input  logic               act_edge,
   input  logic               any_edge,
   output logic               field_mark,
   output logic [FIELD_W-1:0] field_cnt,
   output logic               field_odd
);
   generate
      if (FIELD_W < 1) begin : g_bad_fw
         $error("rsf_field_track: FIELD_W must be positive");
      end
   endgenerate

   logic bump;

   assign bump       = pulse_mode ? act_edge : any_edge;
   assign field_mark = act_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_cnt <= '0;
         field_odd <= 1'b0;
      end else begin
         if (bump) field_cnt <= field_cnt + 1'b1;
         if (pulse_mode) begin
            if (act_edge) field_odd <= ~field_odd;
         end else begin
            field_odd <= (level == rise_active);
         end
      end
   end

   a_r9_flag_counts_both: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode && any_edge) |=> field_cnt == $past(field_cnt) + 1'b1);

   a_r10_pulse_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && act_edge) |=> field_odd != $past(field_odd));

   a_r10_inactive_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && !act_edge && $past(pulse_mode)) |=> $stable(field_cnt));

endmodule

// File: rtl/rsf_phase_seq.sv
module rsf_phase_seq
   import rsf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        advance,
   output comp_phase_e phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= PH_CB;
      else if (restart) phase <= PH_CB;
      else if (advance) phase <= phase_step(phase);
   end

   a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> phase == PH_CB);

   a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !advance) |=> $stable(phase));

endmodule

// File: rtl/rsf_raster_cnt.sv
module rsf_raster_cnt #(
   parameter int SAMPLE_W = 11,
   parameter int LINE_W   = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_edge,
   input  logic                f_mark,
   input  logic [SAMPLE_W-1:0] line_len,
   output logic [SAMPLE_W-1:0] sample_cnt,
   output logic [LINE_W-1:0]   line_cnt,
   output logic                encoding,
   output logic                restart,
   output logic                advance
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_sw
         $error("rsf_raster_cnt: SAMPLE_W must be at least 2");
      end
      if (LINE_W < 1) begin : g_bad_lw
         $error("rsf_raster_cnt: LINE_W must be positive");
      end
   endgenerate

   logic                armed;
   logic                pend;
   logic                clr;
   logic                at_end;
   logic [SAMPLE_W-1:0] last_idx;

   assign last_idx = line_len - 1'b1;
   assign at_end   = (sample_cnt >= last_idx);
   assign restart  = h_edge & (encoding | armed | f_mark);
   assign clr      = restart & (pend | f_mark);
   assign advance  = encoding & ~restart & ~at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         pend       <= 1'b0;
         encoding   <= 1'b0;
         sample_cnt <= '0;
         line_cnt   <= '0;
      end else begin
         if (f_mark) armed <= 1'b1;
         if (f_mark && !h_edge) pend <= 1'b1;
         else if (restart)      pend <= 1'b0;
         if (restart) encoding <= 1'b1;
         if (restart)      sample_cnt <= '0;
         else if (advance) sample_cnt <= sample_cnt + 1'b1;
         if (clr)          line_cnt <= '0;
         else if (restart) line_cnt <= line_cnt + 1'b1;
      end
   end

   a_r4_encode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      encoding |=> encoding);

   a_r4_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!encoding && !(h_edge && (armed || f_mark))) |=> !encoding);

   a_r5_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (h_edge && encoding) |=> sample_cnt == '0);

   a_r6_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (encoding && !h_edge && sample_cnt == last_idx && $stable(line_len))
      |=> sample_cnt == $past(sample_cnt));

   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (encoding && !h_edge && sample_cnt < last_idx)
      |=> sample_cnt == $past(sample_cnt) + 1'b1);

   a_r8_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (h_edge && (pend || f_mark) && (encoding || armed || f_mark)) |=> line_cnt == '0);

endmodule

// File: rtl/raster_sync_follower.sv
module raster_sync_follower
   import rsf_pkg::*;
#(
   parameter int SAMPLE_W = 11,
   parameter int LINE_W   = 10,
   parameter int FIELD_W  = 8,
   parameter int MAX_DLY  = 3,
   parameter int DLY_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_field_pulse,
   input  logic                cfg_h_rise,
   input  logic                cfg_f_rise,
   input  logic [DLY_W-1:0]    cfg_sync_dly,
   input  logic [SAMPLE_W-1:0] cfg_line_len,
   input  logic                hsync_in,
   input  logic                field_in,
   output logic [SAMPLE_W-1:0] sample_cnt,
   output logic [LINE_W-1:0]   line_cnt,
   output logic [FIELD_W-1:0]  field_cnt,
   output logic [1:0]          comp_phase,
   output logic                encoding,
   output logic                field_odd
);
   logic        h_level, h_act, h_any, h_primed;
   logic        f_level, f_act, f_any, f_primed;
   logic        f_mark;
   logic        restart, advance;
   comp_phase_e phase;

   rsf_sync_tap #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_htap (
      .clk(clk), .rst_n(rst_n), .din(hsync_in), .rise_active(cfg_h_rise),
      .dly(cfg_sync_dly), .level(h_level), .act_edge(h_act),
      .any_edge(h_any), .primed(h_primed)
   );

   rsf_sync_tap #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_ftap (
      .clk(clk), .rst_n(rst_n), .din(field_in), .rise_active(cfg_f_rise),
      .dly(cfg_sync_dly), .level(f_level), .act_edge(f_act),
      .any_edge(f_any), .primed(f_primed)
   );

   rsf_field_track #(.FIELD_W(FIELD_W)) u_field (
      .clk(clk), .rst_n(rst_n), .pulse_mode(cfg_field_pulse),
      .rise_active(cfg_f_rise), .level(f_level), .act_edge(f_act),
      .any_edge(f_any), .field_mark(f_mark), .field_cnt(field_cnt),
      .field_odd(field_odd)
   );

   rsf_raster_cnt #(.SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .h_edge(h_act), .f_mark(f_mark),
      .line_len(cfg_line_len), .sample_cnt(sample_cnt), .line_cnt(line_cnt),
      .encoding(encoding), .restart(restart), .advance(advance)
   );

   rsf_phase_seq u_phase (
      .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
      .phase(phase)
   );

   assign comp_phase = phase;

   // R7: phase produced by the sequencer stays aligned with the sample counter
   a_r7_phase_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      encoding |-> comp_phase == sample_cnt[1:0]);

   // R3: both taps share one delay and therefore prime together
   a_r3_taps_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      h_primed == f_primed);

   // R4: counters stay idle before lock
   a_r4_idle_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
      !encoding |-> (sample_cnt == '0 && comp_phase == 2'd0));

   wire unused_ok = &{1'b0, h_level, h_any};

endmodule

// File: tb/tb_raster_sync_follower.sv
`timescale 1ns/1ps
module tb_raster_sync_follower;
   localparam int L = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_field_pulse = 1'b0, cfg_h_rise = 1'b1, cfg_f_rise = 1'b1;
   logic [1:0]  cfg_sync_dly = 2'd0;
   logic [10:0] cfg_line_len = 11'(L);
   logic        hsync_in = 1'b0, field_in = 1'b0;
   logic [10:0] sample_cnt;
   logic [9:0]  line_cnt;
   logic [7:0]  field_cnt;
   logic [1:0]  comp_phase;
   logic        encoding, field_odd;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   raster_sync_follower dut (
      .clk(clk), .rst_n(rst_n), .cfg_field_pulse(cfg_field_pulse),
      .cfg_h_rise(cfg_h_rise), .cfg_f_rise(cfg_f_rise),
      .cfg_sync_dly(cfg_sync_dly), .cfg_line_len(cfg_line_len),
      .hsync_in(hsync_in), .field_in(field_in), .sample_cnt(sample_cnt),
      .line_cnt(line_cnt), .field_cnt(field_cnt), .comp_phase(comp_phase),
      .encoding(encoding), .field_odd(field_odd)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (mode %0d hr %0d fr %0d dly %0d)",
                  req, act, exp, cfg_field_pulse, cfg_h_rise, cfg_f_rise, cfg_sync_dly);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int exp_samp(input int k, input int d);
      int v = k - 1 - d;
      return (v > L - 1) ? L - 1 : v;
   endfunction

   task automatic run_cfg(input int m, input int hr, input int fr, input int d);
      int n;
      int ex;
      cfg_field_pulse = 1'(m);
      cfg_h_rise      = 1'(hr);
      cfg_f_rise      = 1'(fr);
      cfg_sync_dly    = 2'(d);
      hsync_in        = ~cfg_h_rise;
      field_in        = ~cfg_f_rise;
      rst_n           = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(8);
      // R1 reset state
      chk("R1 sample", int'(sample_cnt), 0);
      chk("R1 line", int'(line_cnt), 0);
      chk("R1 field", int'(field_cnt), 0);
      chk("R1 phase", int'(comp_phase), 0);
      chk("R1 encoding", int'(encoding), 0);
      chk("R1 odd", int'(field_odd), 0);
      // R4: line sync before any field edge is ignored
      hsync_in = cfg_h_rise; tick(2); hsync_in = ~cfg_h_rise; tick(6);
      chk("R4 no lock", int'(encoding), 0);
      chk("R4 idle sample", int'(sample_cnt), 0);
      // field and line edges driven together
      field_in = cfg_f_rise; hsync_in = cfg_h_rise; n = 0;
      tick(2); n = 2;
      hsync_in = ~cfg_h_rise;
      if (m == 1) field_in = ~cfg_f_rise;
      tick(d + 6 - n); n = d + 6;
      chk("R3 sample", int'(sample_cnt), exp_samp(n, d));
      chk("R7 phase", int'(comp_phase), exp_samp(n, d) % 4);
      chk("R4 lock", int'(encoding), 1);
      chk("R8 cleared", int'(line_cnt), 0);
      chk(m == 1 ? "R10 field" : "R9 field", int'(field_cnt), 1);
      chk(m == 1 ? "R10 odd" : "R9 odd", int'(field_odd), 1);
      tick(L + 4 - 5); n = d + 1 + L + 4;
      ex = exp_samp(n, d);
      chk("R6 hold", int'(sample_cnt), ex);
      chk("R6 hold value", int'(sample_cnt), L - 1);
      chk("R7 held phase", int'(comp_phase), (L - 1) % 4);
      chk("R10 inactive edge", int'(field_cnt), 1);
      // late line sync after hold
      hsync_in = cfg_h_rise; tick(2); hsync_in = ~cfg_h_rise;
      tick(d + 4 - 2);
      chk("R5 late restart", int'(sample_cnt), exp_samp(d + 4, d));
      chk("R8 increment", int'(line_cnt), 1);
      // early line sync cuts line short
      hsync_in = cfg_h_rise; tick(2); hsync_in = ~cfg_h_rise;
      tick(d + 1 - 2 > 0 ? d + 1 - 2 : 0);
      if (d + 1 < 2) begin
         // sampled after two edges: count moved one on
         chk("R5 early restart", int'(sample_cnt), 1);
      end else begin
         chk("R5 early restart", int'(sample_cnt), 0);
         chk("R5 phase Cb", int'(comp_phase), 0);
      end
      chk("R8 second", int'(line_cnt), 2);
      tick(3);
      // second field transition
      if (m == 1) begin
         field_in = cfg_f_rise; tick(2); field_in = ~cfg_f_rise; tick(2);
      end else begin
         field_in = ~cfg_f_rise; tick(4);
      end
      chk(m == 1 ? "R10 field two" : "R9 inactive counts", int'(field_cnt), 2);
      chk(m == 1 ? "R10 toggle" : "R9 odd low", int'(field_odd), 0);
      hsync_in = cfg_h_rise; tick(2); hsync_in = ~cfg_h_rise; tick(d + 2 - 2 + 1);
      chk("R5 restart", int'(sample_cnt), exp_samp(d + 3, d));
      chk(m == 1 ? "R10 line clear" : "R9 no clear", int'(line_cnt), m == 1 ? 0 : 3);
      if (m == 0) begin
         field_in = cfg_f_rise; tick(4);
         chk("R9 field three", int'(field_cnt), 3);
         chk("R9 odd high", int'(field_odd), 1);
         hsync_in = cfg_h_rise; tick(2); hsync_in = ~cfg_h_rise; tick(d + 2);
         chk("R8 field clear", int'(line_cnt), 0);
      end
      tick(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      tick(2);
      for (int m = 0; m < 2; m++)
         for (int hr = 0; hr < 2; hr++)
            for (int fr = 0; fr < 2; fr++)
               for (int d = 0; d < 4; d++)
                  run_cfg(m, hr, fr, d);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule